// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers sixteen interrupt sources for a small signal-processing core. Five of them feed core-level slots directly: a serial receive event, a serial transmit event, a timer tick and two software requests. The other eleven come from peripherals: nine programmable I/O lines, a PWM sync pulse and a PWM trip input. Each peripheral source is edge-detected and held in a second-level pending register. The enabled pending bits are ORed onto one shared peripheral line, and that line occupies its own core-level slot.

The core side latches its edge-triggered slots, applies a per-slot enable, and presents the winning slot number on a vector output together with a valid flag. The lowest slot number wins. The core clears a slot by acknowledging it. Software clears a peripheral bit by writing a one to that bit's position in the second-level pending register. A mode bit replaces the two serial events with two external interrupt pins.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all masks, all pending bits and the mode bit are zero, `irq_valid` and `peri_irq` are low, and every register reads zero.
- R2: A rising edge on a peripheral source sets its pending bit at the next clock edge, whether or not the source is enabled. The bit positions are pio_in[0..8] at bits 0..8, pwm_sync at bit 9 and pwm_trip at bit 10. A source that is held high sets its bit only once.
- R3: Writing register 3 clears every peripheral pending bit whose data bit is one and leaves the other bits alone. If a new edge arrives on a bit in the same cycle as its clear, the bit stays set.
- R4: `peri_irq` is high while at least one peripheral pending bit has its enable bit (register 2) set.
- R5: The core slots are 0 = serial receive (or ext_irq[0]), 1 = serial transmit (or ext_irq[1]), 2 = timer, 3 = shared peripheral line, 4 = software 0, 5 = software 1. Slots 0 to 2 latch rising edges. Slot 3 follows `peri_irq` and reads in register 1 at bit 3.
- R6: `irq_valid` is high when some slot is both pending and enabled in register 0, bits 0..5. `irq_vec` then gives the lowest such slot number. A pending slot that is masked is not presented.
- R7: Pulsing `ack` with `ack_idx` clears that core slot at the next edge. Acknowledging slot 3 has no effect.
- R8: Writing register 4 with bit 0 set makes slot 4 pending, and with bit 1 set makes slot 5 pending. Register 4 reads zero.
- R9: Register 5 bit 0 set routes ext_irq[1:0] to slots 1:0 in place of the serial events, which are then ignored. When the bit is clear, ext_irq is ignored.
- R10: Registers 0, 2 and 5 read back the value last written to them. Register 1 reads the core pending view and register 3 reads the peripheral pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| ser_rx_done | input | 1 | Serial receive event |
| ser_tx_done | input | 1 | Serial transmit event |
| ext_irq | input | 2 | External interrupt pins |
| timer_tick | input | 1 | Timer event |
| pio_in | input | 9 | Programmable I/O interrupt lines |
| pwm_sync | input | 1 | PWM sync pulse |
| pwm_trip | input | 1 | PWM trip input |
| ack | input | 1 | Core acknowledge strobe |
| ack_idx | input | 3 | Slot being acknowledged |
| peri_irq | output | 1 | Shared peripheral interrupt line |
| irq_vec | output | 3 | Highest-priority active slot |
| irq_valid | output | 1 | irq_vec holds an active slot |

## Verification
Every result is due one clock edge after its stimulus. This covers a source edge, a register write and an acknowledge, because each of them updates only a register, and `peri_irq`, `irq_vec`, `irq_valid` and `reg_rdata` are then decoded combinationally from that register. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and samples on the following falling edge. Reads are checked one time step after the address is set. The same-cycle races between a set and a clear are set up within a single falling-edge window, so both arrive at the same rising edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DW    = 16;
  localparam int AW    = 3;
  localparam int NCORE = 6;
  localparam int VW    = $clog2(NCORE);

  localparam int SLOT_RX   = 0;
  localparam int SLOT_TX   = 1;
  localparam int SLOT_TMR  = 2;
  localparam int SLOT_PERI = 3;
  localparam int SLOT_SW0  = 4;
  localparam int SLOT_SW1  = 5;

  typedef enum logic [AW-1:0] {
    A_CMASK  = 3'd0,
    A_CPEND  = 3'd1,
    A_PMASK  = 3'd2,
    A_PPEND  = 3'd3,
    A_SWTRIG = 3'd4,
    A_MODE   = 3'd5
  } reg_addr_e;

  // lowest set index wins
  function automatic logic [VW-1:0] pick_lowest(input logic [NCORE-1:0] act);
    logic [VW-1:0] r;
    r = '0;
    for (int i = NCORE - 1; i >= 0; i--) begin
      if (act[i]) r = VW'(i);
    end
    return r;
  endfunction

  function automatic logic [NCORE-1:0] slot_decode(input logic en,
                                                   input logic [VW-1:0] idx);
    logic [NCORE-1:0] r;
    r = '0;
    for (int i = 0; i < NCORE; i++) begin
      if (en && idx == VW'(i)) r[i] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NP = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [NCORE-1:0] cpend_view,
  input  logic [NP-1:0]    ppend,
  output logic [DW-1:0]    rdata,
  output logic [NCORE-1:0] cmask,
  output logic [NP-1:0]    pmask,
  output logic             mode_ext,
  output logic [NP-1:0]    pclr,
  output logic [1:0]       swset
);
  reg_addr_e a;
  assign a = reg_addr_e'(addr);

  logic wr_cmask, wr_pmask, wr_mode;
  assign wr_cmask = we && (a == A_CMASK);
  assign wr_pmask = we && (a == A_PMASK);
  assign wr_mode  = we && (a == A_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmask    <= '0;
      pmask    <= '0;
      mode_ext <= 1'b0;
    end else begin
      if (wr_cmask) cmask    <= wdata[NCORE-1:0];
      if (wr_pmask) pmask    <= wdata[NP-1:0];
      if (wr_mode)  mode_ext <= wdata[0];
    end
  end

  assign pclr  = (we && a == A_PPEND)  ? wdata[NP-1:0] : '0;
  assign swset = (we && a == A_SWTRIG) ? wdata[1:0]    : 2'b00;

  always_comb begin
    rdata = '0;
    case (a)
      A_CMASK: rdata = {{(DW-NCORE){1'b0}}, cmask};
      A_CPEND: rdata = {{(DW-NCORE){1'b0}}, cpend_view};
      A_PMASK: rdata = {{(DW-NP){1'b0}}, pmask};
      A_PPEND: rdata = {{(DW-NP){1'b0}}, ppend};
      A_MODE:  rdata = {{(DW-1){1'b0}}, mode_ext};
      default: rdata = '0;
    endcase
  end

  // R10
  cmask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmask |=> $stable(cmask));
  // R10
  pmask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pmask |=> $stable(pmask));
endmodule

// File: rtl/irqc_peri.sv
module irqc_peri #(
  parameter int NP = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] src,
  input  logic [NP-1:0] clr,
  input  logic [NP-1:0] mask,
  output logic [NP-1:0] pend,
  output logic          line
);
  logic [NP-1:0] prev_q, pend_q, rise;

  assign rise = src & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= src;
      pend_q <= (pend_q & ~clr) | rise;
    end
  end

  assign pend = pend_q;
  assign line = |(pend_q & mask);

  for (genvar i = 0; i < NP; i++) begin : g_chk
    // R2
    rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> pend_q[i]);
    // R3
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !rise[i]) |=> !pend_q[i]);
    // R2
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[i] && !rise[i]) |=> $stable(pend_q[i]));
  end
endmodule

// File: rtl/irqc_core.sv
module irqc_core
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_rx,
  input  logic             ser_tx,
  input  logic [1:0]       ext_in,
  input  logic             mode_ext,
  input  logic             timer_in,
  input  logic             peri_line,
  input  logic [1:0]       swset,
  input  logic             ack,
  input  logic [VW-1:0]    ack_idx,
  input  logic [NCORE-1:0] cmask,
  output logic [NCORE-1:0] view,
  output logic [VW-1:0]    vec,
  output logic             valid
);
  logic [1:0]       ser_sel;
  logic [2:0]       hw_src, prev_q, hw_rise;
  logic [NCORE-1:0] pend_q, set_v, ack_v, act;

  assign ser_sel = mode_ext ? ext_in : {ser_tx, ser_rx};
  assign hw_src  = {timer_in, ser_sel};
  assign hw_rise = hw_src & ~prev_q;

  assign set_v = {swset, 1'b0, hw_rise};
  assign ack_v = slot_decode(ack, ack_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= hw_src;
      pend_q <= (pend_q & ~ack_v) | set_v;
    end
  end

  always_comb begin
    view = pend_q;
    view[SLOT_PERI] = peri_line;
  end

  assign act   = view & cmask;
  assign vec   = pick_lowest(act);
  assign valid = |act;

  // R6
  vec_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (view[vec] && cmask[vec]));
  // R6
  no_higher_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((view & cmask & ((NCORE'(1) << vec) - NCORE'(1))) == '0));
  // R8
  sw0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swset[0] |=> pend_q[SLOT_SW0]);
  // R8
  sw1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swset[1] |=> pend_q[SLOT_SW1]);

  for (genvar i = 0; i < NCORE; i++) begin : g_ack
    if (i != SLOT_PERI) begin : g_on
      // R7
      ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_v[i] && !set_v[i]) |=> !pend_q[i]);
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int NPIO = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [15:0]     reg_wdata,
  output logic [15:0]     reg_rdata,
  input  logic            ser_rx_done,
  input  logic            ser_tx_done,
  input  logic [1:0]      ext_irq,
  input  logic            timer_tick,
  input  logic [NPIO-1:0] pio_in,
  input  logic            pwm_sync,
  input  logic            pwm_trip,
  input  logic            ack,
  input  logic [2:0]      ack_idx,
  output logic            peri_irq,
  output logic [2:0]      irq_vec,
  output logic            irq_valid
);
  localparam int NP = NPIO + 2;

  logic [NCORE-1:0] cmask, cview;
  logic [NP-1:0]    pmask, ppend, pclr, psrc;
  logic [1:0]       swset;
  logic             mode_ext;

  assign psrc = {pwm_trip, pwm_sync, pio_in};

  irqc_regs #(.NP(NP)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .cpend_view(cview), .ppend(ppend), .rdata(reg_rdata), .cmask(cmask),
    .pmask(pmask), .mode_ext(mode_ext), .pclr(pclr), .swset(swset)
  );

  irqc_peri #(.NP(NP)) u_peri (
    .clk(clk), .rst_n(rst_n), .src(psrc), .clr(pclr), .mask(pmask),
    .pend(ppend), .line(peri_irq)
  );

  irqc_core u_core (
    .clk(clk), .rst_n(rst_n), .ser_rx(ser_rx_done), .ser_tx(ser_tx_done),
    .ext_in(ext_irq), .mode_ext(mode_ext), .timer_in(timer_tick),
    .peri_line(peri_irq), .swset(swset), .ack(ack), .ack_idx(ack_idx),
    .cmask(cmask), .view(cview), .vec(irq_vec), .valid(irq_valid)
  );

  // R4
  peri_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmask[SLOT_PERI] && peri_irq && !cview[0] && !cview[1] && !cview[2])
      |-> (irq_valid && irq_vec == 3'd3));
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ser_rx_done = 1'b0, ser_tx_done = 1'b0, timer_tick = 1'b0;
  logic [1:0]  ext_irq = '0;
  logic [8:0]  pio_in = '0;
  logic        pwm_sync = 1'b0, pwm_trip = 1'b0;
  logic        ack = 1'b0;
  logic [2:0]  ack_idx = '0;
  logic        peri_irq, irq_valid;
  logic [2:0]  irq_vec;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_rx_done(ser_rx_done),
    .ser_tx_done(ser_tx_done), .ext_irq(ext_irq), .timer_tick(timer_tick),
    .pio_in(pio_in), .pwm_sync(pwm_sync), .pwm_trip(pwm_trip), .ack(ack),
    .ack_idx(ack_idx), .peri_irq(peri_irq), .irq_vec(irq_vec),
    .irq_valid(irq_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_ack(input logic [2:0] idx);
    ack = 1'b1; ack_idx = idx;
    tick();
    ack = 1'b0;
  endtask

  task automatic vec_is(input string tag, input logic v, input logic [2:0] idx);
    chk({tag, " valid"}, {31'b0, irq_valid}, {31'b0, v});
    if (v) chk({tag, " vec"}, {29'b0, irq_vec}, {29'b0, idx});
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reg reset", {16'b0, d}, 32'h0);
    end
    chk("R1 peri_irq reset", {31'b0, peri_irq}, 0);
    chk("R1 valid reset", {31'b0, irq_valid}, 0);
  endtask

  task automatic t_peri_masked();
    logic [15:0] d;
    pio_in[4] = 1'b1; tick(); pio_in[4] = 1'b0;
    rd(3'd3, d);
    chk("R2 pio4 latched while masked", {16'b0, d}, 32'h10);
    chk("R4 line low when masked", {31'b0, peri_irq}, 0);
    pio_in[7] = 1'b1; tick();
    rd(3'd3, d);
    chk("R2 pio7 latched", {16'b0, d}, 32'h90);
    wr(3'd3, 16'h0080);
    tick();
    rd(3'd3, d);
    chk("R2 held level sets once / R3 w1c keeps others", {16'b0, d}, 32'h10);
    pio_in[7] = 1'b0; tick();
  endtask

  task automatic t_peri_unmask();
    logic [15:0] d;
    wr(3'd2, 16'h0010);
    chk("R4 line high when enabled", {31'b0, peri_irq}, 1);
    rd(3'd2, d);
    chk("R10 pmask readback", {16'b0, d}, 32'h10);
    wr(3'd0, 16'h003F);
    rd(3'd0, d);
    chk("R10 cmask readback", {16'b0, d}, 32'h3F);
    vec_is("R5 peri slot", 1'b1, 3'd3);
    rd(3'd1, d);
    chk("R5 cpend bit3", {16'b0, d}, 32'h8);
    do_ack(3'd3);
    vec_is("R7 ack slot3 no effect", 1'b1, 3'd3);
    wr(3'd3, 16'h0010);
    chk("R3 clear drops line", {31'b0, peri_irq}, 0);
    vec_is("R3 clear drops vec", 1'b0, 3'd0);
  endtask

  task automatic t_sync_trip();
    logic [15:0] d;
    pwm_sync = 1'b1; pwm_trip = 1'b1; tick();
    pwm_sync = 1'b0; pwm_trip = 1'b0;
    rd(3'd3, d);
    chk("R2 sync bit9 trip bit10", {16'b0, d}, 32'h600);
    wr(3'd3, 16'h0600);
    rd(3'd3, d);
    chk("R3 sync/trip cleared", {16'b0, d}, 32'h0);
  endtask

  task automatic t_priority();
    logic [15:0] d;
    timer_tick = 1'b1; tick(); timer_tick = 1'b0;
    vec_is("R5 timer slot", 1'b1, 3'd2);
    wr(3'd4, 16'h0002);
    vec_is("R6 timer over sw1", 1'b1, 3'd2);
    rd(3'd1, d);
    chk("R8 sw1 pending", {16'b0, d}, 32'h24);
    rd(3'd4, d);
    chk("R8 swtrig reads zero", {16'b0, d}, 32'h0);
    ser_rx_done = 1'b1; tick(); ser_rx_done = 1'b0;
    vec_is("R6 rx highest", 1'b1, 3'd0);
    do_ack(3'd0);
    vec_is("R7 after ack0", 1'b1, 3'd2);
    do_ack(3'd2);
    vec_is("R7 after ack2", 1'b1, 3'd5);
    wr(3'd4, 16'h0001);
    vec_is("R8 sw0 over sw1", 1'b1, 3'd4);
    do_ack(3'd4);
    do_ack(3'd5);
    vec_is("R7 all acked", 1'b0, 3'd0);
  endtask

  task automatic t_core_mask();
    logic [15:0] d;
    wr(3'd0, 16'h0000);
    timer_tick = 1'b1; tick(); timer_tick = 1'b0;
    vec_is("R6 masked slot hidden", 1'b0, 3'd0);
    rd(3'd1, d);
    chk("R6 masked still pending", {16'b0, d}, 32'h4);
    wr(3'd0, 16'h0004);
    vec_is("R6 unmask presents", 1'b1, 3'd2);
    do_ack(3'd2);
    wr(3'd0, 16'h003F);
  endtask

  task automatic t_mode();
    logic [15:0] d;
    wr(3'd5, 16'h0001);
    rd(3'd5, d);
    chk("R10 mode readback", {16'b0, d}, 32'h1);
    ser_rx_done = 1'b1; tick(); ser_rx_done = 1'b0;
    vec_is("R9 serial ignored in ext mode", 1'b0, 3'd0);
    ext_irq[1] = 1'b1; tick(); ext_irq[1] = 1'b0;
    vec_is("R9 ext1 to slot1", 1'b1, 3'd1);
    do_ack(3'd1);
    wr(3'd5, 16'h0000);
    ext_irq[0] = 1'b1; tick(); ext_irq[0] = 1'b0;
    vec_is("R9 ext ignored in serial mode", 1'b0, 3'd0);
    ser_tx_done = 1'b1; tick(); ser_tx_done = 1'b0;
    vec_is("R9 tx to slot1", 1'b1, 3'd1);
    do_ack(3'd1);
  endtask

  task automatic t_race();
    logic [15:0] d;
    pio_in[0] = 1'b1; tick(); pio_in[0] = 1'b0; tick();
    pio_in[0] = 1'b1;
    wr(3'd3, 16'h0001);
    pio_in[0] = 1'b0;
    rd(3'd3, d);
    chk("R3 edge beats clear", {16'b0, d}, 32'h1);
    wr(3'd3, 16'h0001);
    rd(3'd3, d);
    chk("R3 final clear", {16'b0, d}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_peri_masked();
    t_peri_unmask();
    t_sync_trip();
    t_priority();
    t_core_mask();
    t_mode();
    t_race();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule